// File: doc/BRIEF.md
# Programmable Sleep Wake-up Timer

This block produces a periodic wake-up interrupt from a slow 32.768 kHz time base. Software sets a 23-bit tick count and a run bit. Each time that many qualifying slow ticks have passed, a sticky interrupt flag is raised. The slow time base reaches the block as a single-cycle tick enable (`tick_en`) in the block's clock domain. A tick is about 30.5 µs, so the longest period is 256 s. When the crystal is the selected source and it is not running, the count freezes. When the RC source is selected, the crystal status is ignored.

If the CPU was powered down when the flag rose, the block holds the CPU until the oscillator has settled. It counts a programmable stabilization delay of four slow ticks per delay unit, with a floor of three units. It then emits a one-cycle release strobe.

Two state machines drive the behaviour. The tick timer has three states:
- `T_OFF`: the run bit is clear, the count is held at 0 and the period tracks the registers.
- `T_HOLD`: the block is enabled, the crystal is selected and the crystal is not running.
- `T_RUN`: the timer counts.

Its transitions are named *disable* (any state to `T_OFF`), *start* (`T_OFF` to `T_RUN`), *stall* (`T_RUN` or `T_OFF` to `T_HOLD`) and *resume* (`T_HOLD` to `T_RUN`). All of them are taken on the same cycle that their condition appears.

The wake controller has three states:
- `W_IDLE`: no wake delay is pending.
- `W_WAIT`: the stabilization count is running.
- `W_GO`: the single release cycle.

Its transitions are named *arm* (`W_IDLE` or `W_GO` to `W_WAIT`, on an expiry during power-down), *settle* (`W_WAIT` to `W_GO`, on the last delay tick) and *done* (`W_GO` to `W_IDLE`).

Top module: `sleep_wake_timer`

## Requirements
- R1: After reset, the register reads are: delay (offset 0) = 0x03, control (offset 1) = 0x00, interval-mid (offset 2) = 0x00, interval-low (offset 3) = 0x00, command (offset 4) = 0x00. After reset `wake_irq` = 0 and `cpu_release` = 0.
- R2: The registers read back what was written. The control byte is {bit 7 = source select (1 = RC, 0 = crystal), bits 6:0 = interval[22:16]}. Offset 2 holds interval[15:8] and offset 3 holds interval[7:0]. `clk_src_rc` follows control bit 7.
- R3: With interval N > 0 and the block running, `wake_irq` is set by the N-th qualifying tick and not before. The count then restarts at 0, so the next expiry again takes exactly N ticks.
- R4: An interval of 0 never sets `wake_irq`.
- R5: The command register has bit 0 = run and bit 1 = flag. While run = 0, ticks are not counted. Clearing run resets the count to 0, so a later run needs a full N ticks.
- R6: When control bit 7 = 0 and `xtal_ok` = 0, ticks are not counted. When bit 7 = 1, ticks count whatever the value of `xtal_ok`.
- R7: A new interval written while the timer runs takes effect only after the current period expires.
- R8: `wake_irq` is sticky. It reads as command bit 1 and is cleared only by writing 1 to command bit 1. Writing 0 to that bit leaves it set.
- R9: If `pd_active` = 1 on the expiry tick, `cpu_release` pulses on the 4×D-th tick after the expiry tick, where D is the delay register value.
- R10: A delay value of 2 or less is treated as 3, which gives 12 ticks.
- R11: If `pd_active` = 0 on the expiry tick, no release follows.
- R12: `cpu_release` lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per slow 32.768 kHz tick |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register offset 0..4 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| xtal_ok | input | 1 | Crystal oscillator running |
| pd_active | input | 1 | CPU is in power-down |
| clk_src_rc | output | 1 | Source select to the external clock mux (1 = RC) |
| wake_irq | output | 1 | Sticky wake-up interrupt |
| cpu_release | output | 1 | One-cycle strobe that frees the CPU after the stabilization delay |

## Verification
A wrong tick count or a stale period shows at `wake_irq` as a flag that rises one or more ticks early or late. For short intervals this is visible within one period. For a mid-period interval change it is visible within two periods.

A stall, disable or count-clear fault shows when a tick that should have been ignored moves the expiry forward. This surfaces at the first expiry after the stimulus.

A wrong delay load or a wrong floor in the wake controller moves the `cpu_release` pulse away from the 4×D-th tick. A stuck `W_GO` state widens the pulse past one cycle. Both appear within at most 4×D+1 ticks of the expiry.

// File: rtl/swt_pkg.sv
package swt_pkg;

    localparam int BYTE_W   = 8;
    localparam int INT_W    = 23;
    localparam int ADDR_W   = 3;
    localparam int TOP_BITS = INT_W - 2 * BYTE_W;

    localparam logic [ADDR_W-1:0] OFS_DLY = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CTL = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_IVM = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_IVL = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_CMD = 3'd4;

    localparam logic [BYTE_W-1:0] DLY_RESET = 8'h03;

    typedef enum logic [1:0] {
        T_OFF  = 2'd0,
        T_RUN  = 2'd1,
        T_HOLD = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_WAIT = 2'd1,
        W_GO   = 2'd2
    } wake_state_e;

    typedef struct packed {
        logic              src_rc;
        logic              run_en;
        logic [INT_W-1:0]  interval;
        logic [BYTE_W-1:0] dly;
    } swt_cfg_t;

endpackage

// File: rtl/swt_regs.sv
module swt_regs
    import swt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              expire,
    output swt_cfg_t          cfg,
    output logic              flag
);

    logic [BYTE_W-1:0]   dly_q;
    logic                src_q;
    logic [TOP_BITS-1:0] iv_top_q;
    logic [BYTE_W-1:0]   iv_mid_q;
    logic [BYTE_W-1:0]   iv_low_q;
    logic                run_q;
    logic                flag_q;
    logic                wr_go;

    assign wr_go = bus_sel && bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q    <= DLY_RESET;
            src_q    <= 1'b0;
            iv_top_q <= '0;
            iv_mid_q <= '0;
            iv_low_q <= '0;
            run_q    <= 1'b0;
        end else if (wr_go) begin
            unique case (bus_addr)
                OFS_DLY: dly_q <= bus_wdata;
                OFS_CTL: begin
                    src_q    <= bus_wdata[BYTE_W-1];
                    iv_top_q <= bus_wdata[TOP_BITS-1:0];
                end
                OFS_IVM: iv_mid_q <= bus_wdata;
                OFS_IVL: iv_low_q <= bus_wdata;
                OFS_CMD: run_q    <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Sticky flag: a new expiry wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (wr_go && bus_addr == OFS_CMD && bus_wdata[1]) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_DLY: bus_rdata = dly_q;
            OFS_CTL: bus_rdata = {src_q, iv_top_q};
            OFS_IVM: bus_rdata = iv_mid_q;
            OFS_IVL: bus_rdata = iv_low_q;
            OFS_CMD: bus_rdata = {{(BYTE_W-2){1'b0}}, flag_q, run_q};
            default: bus_rdata = '0;
        endcase
    end

    assign cfg.src_rc   = src_q;
    assign cfg.run_en   = run_q;
    assign cfg.interval = {iv_top_q, iv_mid_q, iv_low_q};
    assign cfg.dly      = dly_q;
    assign flag         = flag_q;

endmodule

// File: rtl/swt_tick_timer.sv
module swt_tick_timer
    import swt_pkg::*;
#(
    parameter int CNT_W = INT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run_en,
    input  logic             src_rc,
    input  logic             xtal_ok,
    input  logic [CNT_W-1:0] interval,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    tmr_state_e       state_q;
    tmr_state_e       state_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_q;
    logic             clk_good;
    logic             advance;
    logic             last;

    assign clk_good = src_rc || xtal_ok;

    // Next state follows the inputs in the same cycle, so gating is exact.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            T_OFF:  if (run_en) state_nxt = clk_good ? T_RUN : T_HOLD;
            T_RUN:  if (!run_en) state_nxt = T_OFF;
                    else if (!clk_good) state_nxt = T_HOLD;
            T_HOLD: if (!run_en) state_nxt = T_OFF;
                    else if (clk_good) state_nxt = T_RUN;
            default: state_nxt = T_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_OFF;
        else        state_q <= state_nxt;
    end

    assign advance = tick_en && (state_nxt == T_RUN) && (period_q != '0);
    assign last    = (cnt_q == period_q - ONE);
    assign expire  = advance && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            period_q <= '0;
        end else if (state_nxt == T_OFF) begin
            cnt_q    <= '0;
            period_q <= interval;
        end else if (advance) begin
            if (last) begin
                cnt_q    <= '0;
                period_q <= interval;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end else if (period_q == '0) begin
            period_q <= interval;
        end
    end

endmodule

// File: rtl/swt_wake_ctrl.sv
module swt_wake_ctrl
    import swt_pkg::*;
#(
    parameter int DLY_W   = BYTE_W,
    parameter int MIN_DLY = 3,
    parameter int UNIT    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             expire,
    input  logic             pd_active,
    input  logic [DLY_W-1:0] dly,
    output logic             release_o
);

    localparam int               REM_W   = DLY_W + $clog2(UNIT) + 1;
    localparam logic [REM_W-1:0] REM_ONE = {{(REM_W-1){1'b0}}, 1'b1};
    localparam logic [DLY_W-1:0] DLY_MIN = DLY_W'(MIN_DLY);

    wake_state_e      state_q;
    wake_state_e      state_nxt;
    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] rem_nxt;
    logic [DLY_W-1:0] dly_eff;
    logic [REM_W-1:0] span;
    logic             arm;

    assign dly_eff = (dly < DLY_MIN) ? DLY_MIN : dly;
    assign span    = REM_W'(dly_eff) * REM_W'(UNIT);
    assign arm     = expire && pd_active;

    always_comb begin
        state_nxt = state_q;
        rem_nxt   = rem_q;
        unique case (state_q)
            W_IDLE: if (arm) begin
                state_nxt = W_WAIT;
                rem_nxt   = span;
            end
            W_WAIT: if (tick_en) begin
                if (rem_q == REM_ONE) state_nxt = W_GO;
                else                  rem_nxt   = rem_q - REM_ONE;
            end
            W_GO: if (arm) begin
                state_nxt = W_WAIT;
                rem_nxt   = span;
            end else begin
                state_nxt = W_IDLE;
            end
            default: state_nxt = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_nxt;
            rem_q   <= rem_nxt;
        end
    end

    always_comb begin
        release_o = 1'b0;
        unique case (state_q)
            W_GO:    release_o = 1'b1;
            default: release_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sleep_wake_timer.sv
module sleep_wake_timer
    import swt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              xtal_ok,
    input  logic              pd_active,
    output logic              clk_src_rc,
    output logic              wake_irq,
    output logic              cpu_release
);

    swt_cfg_t cfg;
    logic     expire;
    logic     run_en;

    assign run_en     = cfg.run_en;
    assign clk_src_rc = cfg.src_rc;

    swt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .expire    (expire),
        .cfg       (cfg),
        .flag      (wake_irq)
    );

    swt_tick_timer #(.CNT_W(INT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .run_en   (run_en),
        .src_rc   (cfg.src_rc),
        .xtal_ok  (xtal_ok),
        .interval (cfg.interval),
        .expire   (expire)
    );

    swt_wake_ctrl #(.DLY_W(BYTE_W), .MIN_DLY(3), .UNIT(4)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .expire    (expire),
        .pd_active (pd_active),
        .dly       (cfg.dly),
        .release_o (cpu_release)
    );

endmodule

// File: rtl/swt_checker.sv
module swt_checker
    import swt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              clr_bit,
    input logic              xtal_ok,
    input logic              clk_src_rc,
    input logic              run_en,
    input logic              wake_irq,
    input logic              cpu_release
);

    logic clr_wr;
    assign clr_wr = bus_sel && bus_wr && (bus_addr == OFS_CMD) && clr_bit;

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq && !clr_wr) |=> wake_irq);

    // R5
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wake_irq) |=> !wake_irq);

    // R6
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_src_rc && !xtal_ok && !wake_irq) |=> !wake_irq);

    // R12
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_release |=> !cpu_release);

    // R9
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_release) |-> $past(tick_en));

endmodule

bind sleep_wake_timer swt_checker u_swt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .clr_bit     (bus_wdata[1]),
    .xtal_ok     (xtal_ok),
    .clk_src_rc  (clk_src_rc),
    .run_en      (run_en),
    .wake_irq    (wake_irq),
    .cpu_release (cpu_release)
);

// File: tb/tb_sleep_wake_timer.sv
module tb_sleep_wake_timer;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 5;
    localparam logic [22:0] PERIODS [NVEC] = '{23'd1, 23'd2, 23'd5, 23'd37, 23'd259};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       xtal_ok = 1'b0;
    logic       pd_active = 1'b0;
    logic       clk_src_rc;
    logic       wake_irq;
    logic       cpu_release;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  seen_rel = 1'b0;

    sleep_wake_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xtal_ok(xtal_ok), .pd_active(pd_active),
        .clk_src_rc(clk_src_rc), .wake_irq(wake_irq), .cpu_release(cpu_release)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, {24'h0, bus_rdata}, {24'h0, exp});
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            if (cpu_release) seen_rel = 1'b1;
        end
    endtask

    task automatic set_period(input logic [22:0] p, input logic rc);
        wr(3'd1, {rc, p[22:16]});
        wr(3'd2, p[15:8]);
        wr(3'd3, p[7:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 dly", 3'd0, 8'h03);
        rd_chk("R1 ctl", 3'd1, 8'h00);
        rd_chk("R1 ivm", 3'd2, 8'h00);
        rd_chk("R1 ivl", 3'd3, 8'h00);
        rd_chk("R1 cmd", 3'd4, 8'h00);
        check("R1 irq", {31'h0, wake_irq}, 0);
        check("R1 release", {31'h0, cpu_release}, 0);

        // R2 register layout
        wr(3'd1, 8'hA5);
        rd_chk("R2 ctl", 3'd1, 8'hA5);
        check("R2 src", {31'h0, clk_src_rc}, 1);
        wr(3'd2, 8'h5A);
        rd_chk("R2 ivm", 3'd2, 8'h5A);
        wr(3'd1, 8'h00);
        check("R2 src0", {31'h0, clk_src_rc}, 0);

        // R3 period table walk, RC source
        for (int v = 0; v < NVEC; v++) begin
            wr(3'd4, 8'h00);
            set_period(PERIODS[v], 1'b1);
            wr(3'd4, 8'h03);
            tick(int'(PERIODS[v]) - 1);
            check($sformatf("R3 p=%0d early", PERIODS[v]), {31'h0, wake_irq}, 0);
            tick(1);
            check($sformatf("R3 p=%0d first", PERIODS[v]), {31'h0, wake_irq}, 1);
            wr(3'd4, 8'h03);
            tick(int'(PERIODS[v]) - 1);
            check($sformatf("R3 p=%0d reload early", PERIODS[v]), {31'h0, wake_irq}, 0);
            tick(1);
            check($sformatf("R3 p=%0d second", PERIODS[v]), {31'h0, wake_irq}, 1);
        end

        // R8 sticky and write-1-to-clear
        wr(3'd4, 8'h01);
        check("R8 keep", {31'h0, wake_irq}, 1);
        rd_chk("R8 cmd read", 3'd4, 8'h03);
        wr(3'd4, 8'h00);
        wr(3'd4, 8'h02);
        check("R8 clear", {31'h0, wake_irq}, 0);

        // R4 interval 0
        set_period(23'd0, 1'b1);
        wr(3'd4, 8'h01);
        tick(40);
        check("R4 zero", {31'h0, wake_irq}, 0);

        // R5 disable clears the count
        wr(3'd4, 8'h00);
        set_period(23'd6, 1'b1);
        wr(3'd4, 8'h01);
        tick(4);
        wr(3'd4, 8'h00);
        tick(10);
        check("R5 off", {31'h0, wake_irq}, 0);
        wr(3'd4, 8'h01);
        tick(5);
        check("R5 restart early", {31'h0, wake_irq}, 0);
        tick(1);
        check("R5 restart full", {31'h0, wake_irq}, 1);

        // R6 crystal stall, then RC ignores status
        wr(3'd4, 8'h02);
        set_period(23'd3, 1'b0);
        xtal_ok = 1'b0;
        wr(3'd4, 8'h01);
        tick(5);
        check("R6 stall", {31'h0, wake_irq}, 0);
        xtal_ok = 1'b1;
        tick(2);
        check("R6 resume early", {31'h0, wake_irq}, 0);
        tick(1);
        check("R6 resume hit", {31'h0, wake_irq}, 1);
        xtal_ok = 1'b0;
        wr(3'd4, 8'h00);
        wr(3'd4, 8'h02);
        set_period(23'd2, 1'b1);
        wr(3'd4, 8'h01);
        tick(2);
        check("R6 rc ignores xtal", {31'h0, wake_irq}, 1);

        // R7 mid-period interval change
        wr(3'd4, 8'h00);
        wr(3'd4, 8'h02);
        set_period(23'd10, 1'b1);
        wr(3'd4, 8'h01);
        tick(3);
        wr(3'd3, 8'd4);
        tick(6);
        check("R7 old early", {31'h0, wake_irq}, 0);
        tick(1);
        check("R7 old period", {31'h0, wake_irq}, 1);
        wr(3'd4, 8'h03);
        tick(3);
        check("R7 new early", {31'h0, wake_irq}, 0);
        tick(1);
        check("R7 new period", {31'h0, wake_irq}, 1);

        // R9 and R12 wake delay D=5 -> 20 ticks
        wr(3'd4, 8'h00);
        wr(3'd4, 8'h02);
        wr(3'd0, 8'd5);
        set_period(23'd3, 1'b1);
        pd_active = 1'b1;
        wr(3'd4, 8'h01);
        tick(3);
        check("R9 irq", {31'h0, wake_irq}, 1);
        tick(19);
        check("R9 held", {31'h0, cpu_release}, 0);
        tick(1);
        check("R9 release", {31'h0, cpu_release}, 1);
        @(negedge clk);
        check("R12 one cycle", {31'h0, cpu_release}, 0);

        // R10 delay floor: D=1 -> 12 ticks
        wr(3'd4, 8'h00);
        wr(3'd4, 8'h02);
        wr(3'd0, 8'd1);
        set_period(23'd40, 1'b1);
        wr(3'd4, 8'h01);
        tick(40);
        tick(11);
        check("R10 held", {31'h0, cpu_release}, 0);
        tick(1);
        check("R10 release", {31'h0, cpu_release}, 1);
        @(negedge clk);

        // R11 no release without power-down
        wr(3'd4, 8'h00);
        wr(3'd4, 8'h02);
        pd_active = 1'b0;
        wr(3'd0, 8'd3);
        set_period(23'd2, 1'b1);
        wr(3'd4, 8'h01);
        seen_rel = 1'b0;
        tick(2);
        check("R11 irq", {31'h0, wake_irq}, 1);
        wr(3'd4, 8'h00);
        tick(20);
        check("R11 no release", {31'h0, seen_rel}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule